// File: doc/BRIEF.md
# Programmable Pulse-Distance Infrared Frame Decoder

This block turns a one-bit demodulated infrared receiver signal into key bytes. It measures every mark (active level) and every space (idle level) in prescaled ticks, and checks each interval against its own inclusive window. The windows cover the leader mark, the space after the leader (normal data or repeat), the mark that opens each bit, and the spaces that stand for a zero or a one. Bits arrive least significant first. A frame carries one or two address bytes, then a data byte, then the bitwise complement of that data byte. The block can compare the address bytes with a programmed value and check the complement before it accepts the data byte. Accepted bytes enter a small key FIFO that raises an interrupt pulse.

Configuration uses a write-only register port (`cfg_wr`, `cfg_addr`, `cfg_wdata`). Windows are written as `{hi[13:0], lo[13:0]}` in `cfg_wdata[27:0]`. The address map is: 0 control, 1 tick divider `[7:0]`, 2 leader window, 3 data-space window, 4 repeat-space window, 5 bit-mark window, 6 zero-space window, 7 one-space window, 8 timeout limit `[19:0]`, 9 framing (`[6:0]` bit count minus one, `[8]` address bytes minus one), 10 address code `[15:0]`, 11 FIFO flush (any write). The control bits are: [0] run, [1] invert input, [2] leader check, [3] bit-mark check, [4] repeat accept, [5] address check, [6] complement check, [7] timeout enable, [8] interrupt mask.

Top module: `pdir_decoder`

## Requirements
- R1: With control bit 1 set, the input level is inverted before any measurement, so a frame driven active-low decodes like the same frame driven active-high with the bit clear.
- R2: One tick is produced every (divider + 1) clock cycles. With divider 0, a level held for L clock cycles measures L ticks; with divider 3 the same windows accept intervals four times as long.
- R3: With control bit 2 set, the leader mark must lie within its window, bounds included, or the frame is dropped. With the bit clear, any leader length is accepted.
- R4: A post-leader space in the data window starts bit reception. Otherwise, if control bit 4 is set and the space lies in the repeat window, the block sets `rpt_flag` and writes no key. With bit 4 clear, such a frame is dropped and the flag is left unchanged.
- R5: With control bit 3 set, each bit mark must lie within the bit-mark window or the frame is dropped. With the bit clear, bit marks are not checked.
- R6: A bit space in the zero window decodes as 0, else a space in the one window decodes as 1, else the frame is dropped. Bits are stored least significant first.
- R7: Framing field [6:0] gives the number of bits minus one, and field [8] gives the number of address bytes minus one. The data byte follows the address bytes, and the complement byte follows the data byte.
- R8: With control bit 5 set, the address bytes must equal the programmed code (its low byte in one-byte mode) or the frame is dropped.
- R9: With control bit 6 set, the data byte must equal the bitwise inverse of the byte after it or the frame is dropped.
- R10: With control bit 7 set, a frame is aborted when the number of ticks since the last edge reaches the timeout limit.
- R11: The interval count saturates at 16383, so a leader longer than that still measures 16383.
- R12: After reset the FIFO is empty and not full. Keys leave in arrival order when `key_pop` is pulsed. `key_full` rises once DEPTH keys are stored, and further keys are dropped.
- R13: Any write to address 11 empties the FIFO.
- R14: Each key written to the FIFO gives a one-cycle `irq` pulse unless control bit 8 is set. Writing a key also clears `rpt_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_in | input | 1 | Demodulated infrared level |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 28 | Configuration write data |
| key_pop | input | 1 | Removes the oldest key |
| key_data | output | 8 | Oldest key byte |
| key_empty | output | 1 | FIFO holds no key |
| key_full | output | 1 | FIFO holds DEPTH keys |
| rpt_flag | output | 1 | A repeat frame was seen since the last key |
| irq | output | 1 | One-cycle pulse per key written |

## Verification
Two cases are the hardest to reach from the pins: saturation of the interval counter, and a timeout that fires inside an otherwise legal frame. The bench reaches saturation with a leader of 17000 cycles against a window whose upper bound is 16383. It reaches the timeout by widening the one-space window so that a 100-cycle bit space is legal, then sending the same frame once with the timeout disabled and once with it enabled. Random addresses and data, some with a corrupted address or complement byte, are decoded with both checks on.

// File: rtl/pdir_pkg.sv
package pdir_pkg;
  localparam int IW   = 14;
  localparam int TOW  = 20;
  localparam int DIVW = 8;
  localparam int NBW  = 7;
  localparam int SRW  = 32;
  localparam int SRBW = $clog2(SRW);

  typedef logic [IW-1:0] ivl_t;

  typedef struct packed {
    ivl_t hi;
    ivl_t lo;
  } win_t;

  typedef struct packed {
    logic           run;
    logic           lead_chk;
    logic           mark_chk;
    logic           rpt_en;
    logic           addr_chk;
    logic           pol_chk;
    logic           to_en;
    win_t           lead_w;
    win_t           dspc_w;
    win_t           rspc_w;
    win_t           mark_w;
    win_t           zero_w;
    win_t           one_w;
    logic [TOW-1:0] to_lim;
    logic [NBW-1:0] nbits_m1;
    logic           abytes_m1;
    logic [15:0]    cust;
  } fcfg_t;

  typedef enum logic [2:0] {
    S_IDLE, S_LEAD, S_LSPC, S_BMARK, S_BSPC, S_DONE
  } fst_t;

  function automatic logic in_win(input ivl_t v, input win_t w);
    return (v >= w.lo) && (v <= w.hi);
  endfunction
endpackage

// File: rtl/pdir_tick.sv
module pdir_tick
  import pdir_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre  <= '0;
      tick <= 1'b0;
    end else if (pre >= div) begin
      pre  <= '0;
      tick <= 1'b1;
    end else begin
      pre  <= pre + 1'b1;
      tick <= 1'b0;
    end
  end

  // R2: when dividing, two ticks never fall on adjacent cycles
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/pdir_fifo.sv
module pdir_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wptr] <= din;
    dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  a_r12_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  a_r12_full_hold: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !clr) |=> full);
  a_r13_flush_empty: assert property (@(posedge clk) disable iff (rst)
    clr |=> empty);
endmodule

// File: rtl/pdir_frame.sv
module pdir_frame
  import pdir_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       sig,
  input  fcfg_t      cfg,
  output logic       key_push,
  output logic [7:0] key_byte,
  output logic       rpt_evt
);
  localparam ivl_t           IVL_MAX = '1;
  localparam logic [TOW-1:0] TO_MAX  = '1;

  fst_t           state;
  logic           prev;
  ivl_t           cnt;
  logic [TOW-1:0] tocnt;
  logic [NBW-1:0] bitcnt;
  logic [SRW-1:0] sr;

  logic edge_s, rise, fall, to_hit, is0, is1;
  logic addr_ok, pol_ok;
  logic [7:0] dbyte, ibyte;

  assign edge_s = sig ^ prev;
  assign rise   = edge_s && sig;
  assign fall   = edge_s && !sig;
  assign to_hit = cfg.to_en && (state inside {S_LEAD, S_LSPC, S_BMARK, S_BSPC})
                  && (tocnt >= cfg.to_lim);
  assign is0    = in_win(cnt, cfg.zero_w);
  assign is1    = in_win(cnt, cfg.one_w);

  always_comb begin
    if (cfg.abytes_m1) begin
      addr_ok = (sr[15:0] == cfg.cust);
      dbyte   = sr[23:16];
      ibyte   = sr[31:24];
    end else begin
      addr_ok = (sr[7:0] == cfg.cust[7:0]);
      dbyte   = sr[15:8];
      ibyte   = sr[23:16];
    end
    pol_ok = (dbyte == ~ibyte);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      prev     <= 1'b0;
      cnt      <= '0;
      tocnt    <= '0;
      bitcnt   <= '0;
      sr       <= '0;
      key_push <= 1'b0;
      key_byte <= '0;
      rpt_evt  <= 1'b0;
    end else begin
      prev     <= sig;
      key_push <= 1'b0;
      rpt_evt  <= 1'b0;
      if (edge_s)                       cnt <= IW'(1);
      else if (tick && cnt != IVL_MAX)  cnt <= cnt + 1'b1;
      if (edge_s)                       tocnt <= '0;
      else if (tick && tocnt != TO_MAX) tocnt <= tocnt + 1'b1;

      if (!cfg.run || to_hit) begin
        state <= S_IDLE;
      end else begin
        unique case (state)
          S_IDLE: if (rise) begin
            state  <= S_LEAD;
            bitcnt <= '0;
            sr     <= '0;
          end
          S_LEAD: if (fall) begin
            state <= (!cfg.lead_chk || in_win(cnt, cfg.lead_w)) ? S_LSPC : S_IDLE;
          end
          S_LSPC: if (rise) begin
            if (in_win(cnt, cfg.dspc_w)) begin
              state <= S_BMARK;
            end else begin
              if (cfg.rpt_en && in_win(cnt, cfg.rspc_w)) rpt_evt <= 1'b1;
              state <= S_IDLE;
            end
          end
          S_BMARK: if (fall) begin
            state <= (!cfg.mark_chk || in_win(cnt, cfg.mark_w)) ? S_BSPC : S_IDLE;
          end
          S_BSPC: if (rise) begin
            if (is0 || is1) begin
              if (bitcnt < NBW'(SRW)) sr[bitcnt[SRBW-1:0]] <= !is0;
              if (bitcnt == cfg.nbits_m1) begin
                state <= S_DONE;
              end else begin
                bitcnt <= bitcnt + 1'b1;
                state  <= S_BMARK;
              end
            end else begin
              state <= S_IDLE;
            end
          end
          S_DONE: begin
            if ((!cfg.addr_chk || addr_ok) && (!cfg.pol_chk || pol_ok)) begin
              key_push <= 1'b1;
              key_byte <= dbyte;
            end
            state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  a_r3_lead_reject: assert property (@(posedge clk) disable iff (rst)
    (state == S_LEAD && fall && cfg.lead_chk && !in_win(cnt, cfg.lead_w))
    |=> state == S_IDLE);
  a_r10_timeout_abort: assert property (@(posedge clk) disable iff (rst)
    to_hit |=> state == S_IDLE);
  a_r4_rpt_source: assert property (@(posedge clk) disable iff (rst)
    rpt_evt |-> $past(state) == S_LSPC);
  a_r11_hold_max: assert property (@(posedge clk) disable iff (rst)
    (cnt == IVL_MAX && !edge_s) |=> cnt == IVL_MAX);
endmodule

// File: rtl/pdir_decoder.sv
module pdir_decoder
  import pdir_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ir_in,
  input  logic         cfg_wr,
  input  logic [3:0]   cfg_addr,
  input  logic [27:0]  cfg_wdata,
  input  logic         key_pop,
  output logic [7:0]   key_data,
  output logic         key_empty,
  output logic         key_full,
  output logic         rpt_flag,
  output logic         irq
);
  fcfg_t           fcfg;
  logic            inv, irq_mask, flush;
  logic [DIVW-1:0] div;
  logic [1:0]      sync;
  logic            tick, key_push, rpt_evt;
  logic [7:0]      key_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      fcfg     <= '0;
      inv      <= 1'b0;
      irq_mask <= 1'b0;
      div      <= '0;
      flush    <= 1'b0;
    end else begin
      flush <= 1'b0;
      if (cfg_wr) begin
        unique case (cfg_addr)
          4'd0: begin
            fcfg.run      <= cfg_wdata[0];
            inv           <= cfg_wdata[1];
            fcfg.lead_chk <= cfg_wdata[2];
            fcfg.mark_chk <= cfg_wdata[3];
            fcfg.rpt_en   <= cfg_wdata[4];
            fcfg.addr_chk <= cfg_wdata[5];
            fcfg.pol_chk  <= cfg_wdata[6];
            fcfg.to_en    <= cfg_wdata[7];
            irq_mask      <= cfg_wdata[8];
          end
          4'd1:  div         <= cfg_wdata[DIVW-1:0];
          4'd2:  fcfg.lead_w <= cfg_wdata;
          4'd3:  fcfg.dspc_w <= cfg_wdata;
          4'd4:  fcfg.rspc_w <= cfg_wdata;
          4'd5:  fcfg.mark_w <= cfg_wdata;
          4'd6:  fcfg.zero_w <= cfg_wdata;
          4'd7:  fcfg.one_w  <= cfg_wdata;
          4'd8:  fcfg.to_lim <= cfg_wdata[TOW-1:0];
          4'd9: begin
            fcfg.nbits_m1  <= cfg_wdata[NBW-1:0];
            fcfg.abytes_m1 <= cfg_wdata[8];
          end
          4'd10: fcfg.cust <= cfg_wdata[15:0];
          4'd11: flush     <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync     <= '0;
      rpt_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      sync <= {sync[0], ir_in};
      irq  <= key_push && !irq_mask;
      if (key_push)     rpt_flag <= 1'b0;
      else if (rpt_evt) rpt_flag <= 1'b1;
    end
  end

  pdir_tick u_tick (
    .clk  (clk),
    .rst  (rst),
    .div  (div),
    .tick (tick)
  );

  pdir_frame u_frame (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .sig      (sync[1] ^ inv),
    .cfg      (fcfg),
    .key_push (key_push),
    .key_byte (key_byte),
    .rpt_evt  (rpt_evt)
  );

  pdir_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .clr   (flush),
    .push  (key_push),
    .din   (key_byte),
    .pop   (key_pop),
    .dout  (key_data),
    .empty (key_empty),
    .full  (key_full)
  );

  a_r14_irq_mask: assert property (@(posedge clk) disable iff (rst)
    irq |-> !$past(irq_mask));
  a_r14_rpt_clear: assert property (@(posedge clk) disable iff (rst)
    key_push |=> !rpt_flag);
endmodule

// File: tb/pdir_decoder_test.sv
module pdir_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ir_in = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [27:0] cfg_wdata = '0;
  logic        key_pop = 1'b0;
  logic [7:0]  key_data;
  logic        key_empty, key_full, rpt_flag, irq;

  int total = 0, bad = 0, irq_cnt = 0;
  bit finished = 0;

  int inv_phys = 0, sc = 1;
  int t_lead, t_lspc, t_mark, t_zero, t_one, t_rpt;
  int long_idx = -1, long_len = 0;

  localparam int CT_BASE = 32'h07D;  // run, lead, mark, rpt, addr, pol

  always #4 clk = ~clk;

  pdir_decoder uut (
    .clk(clk), .rst(rst), .ir_in(ir_in), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .key_pop(key_pop), .key_data(key_data),
    .key_empty(key_empty), .key_full(key_full), .rpt_flag(rpt_flag), .irq(irq)
  );

  always @(posedge clk) if (irq) irq_cnt++;

  function automatic logic [27:0] win(input int lo, input int hi);
    return {14'(hi), 14'(lo)};
  endfunction

  function automatic logic [31:0] frm(input logic [15:0] a, input logic [7:0] d,
                                      input logic [7:0] iv);
    return {iv, d, a};
  endfunction

  function automatic bit exp_ok(input int kind, input bit achk, input bit pchk);
    return (kind == 0) || (kind == 1 && !achk) || (kind == 2 && !pchk);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [27:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic drv(input logic lv, input int n);
    ir_in = lv ^ logic'(inv_phys);
    repeat (n) @(negedge clk);
  endtask

  task automatic times_default();
    t_lead = 40; t_lspc = 20; t_mark = 6; t_zero = 6; t_one = 16; t_rpt = 10;
    long_idx = -1; sc = 1; inv_phys = 0;
  endtask

  task automatic send(input logic [31:0] bits, input int n);
    @(negedge clk);
    drv(1'b1, t_lead * sc);
    drv(1'b0, t_lspc * sc);
    for (int i = 0; i < n; i++) begin
      drv(1'b1, t_mark * sc);
      if (i == long_idx) drv(1'b0, long_len);
      else drv(1'b0, (bits[i] ? t_one : t_zero) * sc);
    end
    drv(1'b1, t_mark * sc);
    drv(1'b0, 60 * sc);
  endtask

  task automatic send_rpt();
    @(negedge clk);
    drv(1'b1, t_lead);
    drv(1'b0, t_rpt);
    drv(1'b1, t_mark);
    drv(1'b0, 60);
  endtask

  task automatic pop();
    @(negedge clk); key_pop = 1'b1;
    @(negedge clk); key_pop = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // checks for one key (or none), then leaves the FIFO empty
  task automatic expect_key(input string tag, input bit valid, input logic [7:0] d);
    chk(tag, int'(key_empty), int'(!valid));
    if (valid && !key_empty) begin
      chk(tag, int'(key_data), int'(d));
      pop();
    end
  endtask

  task automatic base_cfg();
    wr(1, 28'd0);
    wr(2, win(38, 42));
    wr(3, win(18, 22));
    wr(4, win(8, 12));
    wr(5, win(5, 7));
    wr(6, win(5, 7));
    wr(7, win(14, 18));
    wr(8, 28'd60);
    wr(9, 28'h11F);
    wr(10, 28'h1234);
    wr(0, 28'(CT_BASE));
  endtask

  initial begin
    logic [15:0] a;
    logic [7:0]  d;
    int          kind, ic;
    void'($urandom(32'd1207));
    times_default();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 reset empty", int'(key_empty), 1);
    chk("R12 reset full", int'(key_full), 0);
    chk("R4 reset rpt", int'(rpt_flag), 0);
    chk("R14 reset irq", int'(irq), 0);
    base_cfg();

    // R6 R7 basic frame
    ic = irq_cnt;
    send(frm(16'h1234, 8'h5A, 8'hA5), 32);
    expect_key("R6 basic frame", 1, 8'h5A);
    chk("R14 irq pulse", irq_cnt - ic, 1);

    // R8 R9 random frames, both checks on
    for (int k = 0; k < 16; k++) begin
      d = 8'($urandom);
      kind = int'($urandom % 3);
      a = (kind == 1) ? 16'h1234 ^ 16'(1 << ($urandom % 16)) : 16'h1234;
      send(frm(a, d, (kind == 2) ? ~d ^ 8'h10 : ~d), 32);
      expect_key(kind == 1 ? "R8 random addr" : "R9 random data", exp_ok(kind, 1, 1), d);
    end

    // R3 leader bounds
    t_lead = 38; send(frm(16'h1234, 8'h01, 8'hFE), 32); expect_key("R3 lead lo", 1, 8'h01);
    t_lead = 42; send(frm(16'h1234, 8'h02, 8'hFD), 32); expect_key("R3 lead hi", 1, 8'h02);
    t_lead = 37; send(frm(16'h1234, 8'h03, 8'hFC), 32); expect_key("R3 lead below", 0, 8'h00);
    t_lead = 43; send(frm(16'h1234, 8'h04, 8'hFB), 32); expect_key("R3 lead above", 0, 8'h00);
    t_lead = 100; wr(0, 28'(CT_BASE & ~32'h4));
    send(frm(16'h1234, 8'h05, 8'hFA), 32); expect_key("R3 lead unchecked", 1, 8'h05);
    wr(0, 28'(CT_BASE)); times_default();

    // R5 bit-mark window
    t_mark = 9; send(frm(16'h1234, 8'h06, 8'hF9), 32); expect_key("R5 mark checked", 0, 8'h00);
    wr(0, 28'(CT_BASE & ~32'h8));
    send(frm(16'h1234, 8'h07, 8'hF8), 32); expect_key("R5 mark unchecked", 1, 8'h07);
    wr(0, 28'(CT_BASE)); times_default();

    // R6 space in neither window
    long_idx = 20; long_len = 10;
    send(frm(16'h1234, 8'h08, 8'hF7), 32); expect_key("R6 bad space", 0, 8'h00);
    times_default();

    // R4 repeat frames, R14 flag cleared by a key
    send_rpt();
    chk("R4 repeat flag", int'(rpt_flag), 1);
    chk("R4 repeat no key", int'(key_empty), 1);
    send(frm(16'h1234, 8'h09, 8'hF6), 32); expect_key("R14 key after repeat", 1, 8'h09);
    chk("R14 rpt cleared", int'(rpt_flag), 0);
    wr(0, 28'(CT_BASE & ~32'h10));
    send_rpt();
    chk("R4 repeat disabled", int'(rpt_flag), 0);
    wr(0, 28'(CT_BASE));

    // R8 R9 checks disabled
    wr(0, 28'(CT_BASE & ~32'h20));
    send(frm(16'h4321, 8'h0A, 8'hF5), 32); expect_key("R8 addr unchecked", 1, 8'h0A);
    wr(0, 28'(CT_BASE & ~32'h40));
    send(frm(16'h1234, 8'h0B, 8'h00), 32); expect_key("R9 data unchecked", 1, 8'h0B);
    wr(0, 28'(CT_BASE));

    // R7 one address byte, 24 bits
    wr(9, 28'h017);
    send({8'h0, 8'hF3, 8'h0C, 8'h34}, 24); expect_key("R7 one addr byte", 1, 8'h0C);
    send({8'h0, 8'hF2, 8'h0D, 8'h35}, 24); expect_key("R8 one byte mismatch", 0, 8'h00);
    wr(9, 28'h11F);

    // R1 inverted input
    wr(0, 28'(CT_BASE | 32'h2)); inv_phys = 1;
    @(negedge clk); ir_in = 1'b1; repeat (20) @(negedge clk);
    send(frm(16'h1234, 8'h0E, 8'hF1), 32); expect_key("R1 inverted", 1, 8'h0E);
    inv_phys = 0; ir_in = 1'b0; wr(0, 28'(CT_BASE)); repeat (20) @(negedge clk);

    // R2 divider
    wr(1, 28'd3); sc = 4;
    send(frm(16'h1234, 8'h0F, 8'hF0), 32); expect_key("R2 div 3", 1, 8'h0F);
    wr(1, 28'd0);
    send(frm(16'h1234, 8'h10, 8'hEF), 32); expect_key("R2 div 0 long", 0, 8'h00);
    times_default();

    // R10 timeout against a legal long space
    wr(7, win(14, 200)); long_idx = 12; long_len = 100;
    send(frm(16'h1234, 8'h11, 8'hEE), 32); expect_key("R10 timeout off", 1, 8'h11);
    wr(0, 28'(CT_BASE | 32'h80));
    send(frm(16'h1234, 8'h12, 8'hED), 32); expect_key("R10 timeout on", 0, 8'h00);
    wr(0, 28'(CT_BASE)); wr(7, win(14, 18)); times_default();

    // R11 saturation of leader count
    wr(2, win(16000, 16383)); t_lead = 17000;
    send(frm(16'h1234, 8'h13, 8'hEC), 32); expect_key("R11 saturate", 1, 8'h13);
    wr(2, win(38, 42)); times_default();

    // R12 fill, overflow drop, order
    for (int k = 0; k < 9; k++) begin
      send(frm(16'h1234, 8'(8'h20 + k), ~8'(8'h20 + k)), 32);
      if (k == 7) chk("R12 full at depth", int'(key_full), 1);
    end
    chk("R12 still full", int'(key_full), 1);
    for (int k = 0; k < 8; k++) begin
      chk("R12 order", int'(key_data), 32 + k);
      pop();
      chk("R12 not full after pop", int'(key_full), 0);
    end
    chk("R12 overflow dropped", int'(key_empty), 1);

    // R13 flush
    send(frm(16'h1234, 8'h30, 8'hCF), 32);
    send(frm(16'h1234, 8'h31, 8'hCE), 32);
    wr(11, 28'd0); repeat (3) @(negedge clk);
    chk("R13 flush", int'(key_empty), 1);

    // R14 masked interrupt
    wr(0, 28'(CT_BASE | 32'h100)); ic = irq_cnt;
    send(frm(16'h1234, 8'h32, 8'hCD), 32);
    chk("R14 irq masked", irq_cnt - ic, 0);
    expect_key("R14 masked key", 1, 8'h32);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule